// File: doc/BRIEF.md
# Multi-Master Hardware Semaphore Bank

This block holds a bank of hardware semaphores that several processors on one chip use to take turns on shared resources. Each semaphore has its own 32-bit register. A processor claims one by writing its 4-bit master ID into that register. It then reads the register back. If the low nibble it reads equals its own ID, the claim succeeded; any other value names the master that already holds it. Writing zero hands the semaphore back, and a free semaphore reads as zero.

All accesses arrive on a simple register bus: a byte address, separate write and read strobes, write data and registered read data. A side input carries the ID of the master that issues each access. The block uses that ID to reject forged claims and releases by other masters.

The bank also has two more registers. A mode register selects the locking scheme; the claim and release rules apply only while its low bit is clear, and the semaphores are frozen while it is set. A write-only interrupt-clear register takes the all-flags-clear write and otherwise reads as zero.

Top module: `hw_sem_bank`

## Requirements
- R1: After reset, every semaphore register and the mode register read as zero.
- R2: Semaphore i (0..31) sits at byte address 8 + 4*i, and each semaphore keeps its own owner independently of the others.
- R3: A write to a free semaphore whose data bits [3:0] are nonzero and equal the accessing master's ID makes that ID the owner. A later read returns the owner in bits [3:0] and zero in bits [31:4].
- R4: A nonzero write to a semaphore held by a different master is ignored, and the owner is unchanged.
- R5: A nonzero write of its own ID by the current owner leaves the semaphore owned by that master.
- R6: A write with data bits [3:0] equal to zero from the owning master frees the semaphore. The same write from any other master is ignored.
- R7: A claim on a free semaphore whose data bits [3:0] differ from the accessing master's ID is ignored, and the semaphore stays free.
- R8: The mode register at address 0x00 stores data bit 0 and reads it back in bit 0, with all other bits zero. While bit 0 is 1, every semaphore write is ignored.
- R9: Address 0x90 is a write-only interrupt-clear register. It reads as zero, and writing it, including the value 0xFFFF, changes no semaphore and not the mode register.
- R10: Reads of unmapped or non-word-aligned addresses return zero, and writes to them change no state.
- R11: Read data appears the cycle after the read strobe and is zero in a cycle that follows no read. A read in the same cycle as a write returns the value from before the write, and reads never change state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | 32 | Registered read data, valid the cycle after bus_rd_en |
| bus_master | input | 4 | ID of the master issuing the current access |

## Verification
Every result of this block is due exactly one clock after its stimulus. Read data for a strobe in cycle n is registered at the edge that ends cycle n. A write in cycle n changes the owner, so a read issued in cycle n+1 returns the new value at the end of cycle n+1. The bench drives inputs at the falling edge. At that same falling edge it computes the expected read data from a behavioural model that still holds the state from before the write, and it compares at the next falling edge. This comparison runs on every clock, including idle cycles, which must read zero.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

  // Class of register an address falls into
  typedef enum logic [1:0] {
    HSB_RGN_NONE = 2'd0,
    HSB_RGN_MODE = 2'd1,
    HSB_RGN_SEM  = 2'd2,
    HSB_RGN_ICLR = 2'd3
  } hsb_region_e;

endpackage

// File: rtl/hsb_decode.sv
module hsb_decode
  import hsb_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_SEM  = 32,
  parameter int IDX_W    = 5,
  parameter int SEM_BASE = 8,
  parameter int MODE_OFF = 0,
  parameter int ICLR_OFF = 144
) (
  input  logic [ADDR_W-1:0] addr,
  output hsb_region_e       region,
  output logic [IDX_W-1:0]  sem_idx
);

  localparam logic [ADDR_W-1:0] SEM_LO = ADDR_W'(SEM_BASE);
  localparam logic [ADDR_W-1:0] SEM_HI = ADDR_W'(SEM_BASE + 4 * NUM_SEM);
  localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_OFF);
  localparam logic [ADDR_W-1:0] ICLR_A = ADDR_W'(ICLR_OFF);

  logic [ADDR_W-1:0] rel_off;

  always_comb begin
    rel_off = addr - SEM_LO;
    sem_idx = IDX_W'(rel_off >> 2);
    if (addr == MODE_A)
      region = HSB_RGN_MODE;
    else if (addr == ICLR_A)
      region = HSB_RGN_ICLR;
    else if ((rel_off[1:0] == 2'b00) && (addr >= SEM_LO) && (addr < SEM_HI))
      region = HSB_RGN_SEM;
    else
      region = HSB_RGN_NONE;
  end

endmodule

// File: rtl/hsb_slot.sv
module hsb_slot #(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_sel,
  input  logic [ID_W-1:0] wr_id,
  input  logic [ID_W-1:0] req_id,
  input  logic            proto_open,
  output logic [ID_W-1:0] owner
);

  logic [ID_W-1:0] owner_q;
  logic [ID_W-1:0] owner_d;
  logic            owner_en;

  // Next-state: claim only a free slot with a matching ID, release only by owner
  always_comb begin
    owner_d  = owner_q;
    owner_en = 1'b0;
    if (wr_sel && proto_open) begin
      if (wr_id == '0) begin
        if ((owner_q != '0) && (owner_q == req_id)) begin
          owner_d  = '0;
          owner_en = 1'b1;
        end
      end else if ((owner_q == '0) && (wr_id == req_id)) begin
        owner_d  = wr_id;
        owner_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      owner_q <= '0;
    else if (owner_en)
      owner_q <= owner_d;
  end

  assign owner = owner_q;

  assert_free_claim_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == '0 && wr_sel && proto_open && wr_id != '0 && wr_id == req_id)
      |=> owner_q == $past(wr_id));

  assert_held_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q != '0 && wr_sel && wr_id != '0) |=> $stable(owner_q));

  assert_owner_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && proto_open && wr_id == '0 && owner_q == req_id) |=> owner_q == '0);

  assert_foreign_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && wr_id == '0 && owner_q != req_id) |=> $stable(owner_q));

  assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!proto_open) |=> $stable(owner_q));

  assert_no_write_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_sel) |=> $stable(owner_q));

endmodule

// File: rtl/hsb_rdmux.sv
module hsb_rdmux
  import hsb_pkg::*;
#(
  parameter int NUM_SEM = 32,
  parameter int ID_W    = 4,
  parameter int IDX_W   = 5,
  parameter int DATA_W  = 32
) (
  input  hsb_region_e                     region,
  input  logic [IDX_W-1:0]                sem_idx,
  input  logic [NUM_SEM-1:0][ID_W-1:0]    owners,
  input  logic                            mode_bit,
  output logic [DATA_W-1:0]               rd_word
);

  always_comb begin
    rd_word = '0;
    unique case (region)
      HSB_RGN_MODE: rd_word[0] = mode_bit;
      HSB_RGN_SEM:  rd_word[ID_W-1:0] = owners[sem_idx];
      default:      rd_word = '0;
    endcase
  end

endmodule

// File: rtl/hw_sem_bank.sv
module hw_sem_bank
  import hsb_pkg::*;
#(
  parameter int NUM_SEM  = 32,
  parameter int ID_W     = 4,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int SEM_BASE = 8,
  parameter int MODE_OFF = 0,
  parameter int ICLR_OFF = 144
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [DATA_W-1:0] bus_wr_data,
  input  logic              bus_rd_en,
  output logic [DATA_W-1:0] bus_rd_data,
  input  logic [ID_W-1:0]   bus_master
);

  localparam int IDX_W = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // Address decode
  hsb_region_e      region;
  logic [IDX_W-1:0] sem_idx;

  hsb_decode #(
    .ADDR_W  (ADDR_W),
    .NUM_SEM (NUM_SEM),
    .IDX_W   (IDX_W),
    .SEM_BASE(SEM_BASE),
    .MODE_OFF(MODE_OFF),
    .ICLR_OFF(ICLR_OFF)
  ) u_decode (
    .addr   (bus_addr),
    .region (region),
    .sem_idx(sem_idx)
  );

  // Mode register
  logic mode_q;
  logic mode_d;
  logic mode_en;

  always_comb begin
    mode_en = bus_wr_en && (region == HSB_RGN_MODE);
    mode_d  = bus_wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)
      mode_q <= 1'b0;
    else if (mode_en)
      mode_q <= mode_d;
  end

  // Semaphore slots
  logic                         sem_wr;
  logic [NUM_SEM-1:0][ID_W-1:0] owners;

  assign sem_wr = bus_wr_en && (region == HSB_RGN_SEM);

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_slot
    logic slot_sel;
    assign slot_sel = sem_wr && (sem_idx == IDX_W'(g));
    hsb_slot #(
      .ID_W(ID_W)
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .wr_sel    (slot_sel),
      .wr_id     (bus_wr_data[ID_W-1:0]),
      .req_id    (bus_master),
      .proto_open(!mode_q),
      .owner     (owners[g])
    );
  end

  // Interrupt-clear writes are decoded and absorbed; no flag state is kept
  logic unused_wdata;
  assign unused_wdata = ^bus_wr_data[DATA_W-1:ID_W];

  // Read path
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] rd_d;

  hsb_rdmux #(
    .NUM_SEM(NUM_SEM),
    .ID_W   (ID_W),
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W)
  ) u_rdmux (
    .region  (region),
    .sem_idx (sem_idx),
    .owners  (owners),
    .mode_bit(mode_q),
    .rd_word (rd_word)
  );

  always_comb begin
    rd_d = bus_rd_en ? rd_word : '0;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)
      rd_q <= '0;
    else
      rd_q <= rd_d;
  end

  assign bus_rd_data = rd_q;

  assert_mode_store_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_wr_en && region == HSB_RGN_MODE) |=> mode_q == $past(bus_wr_data[0]));

  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!(bus_wr_en && region == HSB_RGN_MODE)) |=> $stable(mode_q));

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_rd_en && (region == HSB_RGN_NONE || region == HSB_RGN_ICLR)) |=> bus_rd_data == '0);

  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!bus_rd_en) |=> bus_rd_data == '0);

endmodule

// File: tb/hw_sem_bank_tb.sv
`timescale 1ns/1ps
module hw_sem_bank_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr_en;
  logic [31:0] bus_wr_data;
  logic        bus_rd_en;
  logic [31:0] bus_rd_data;
  logic [3:0]  bus_master;

  always #2 clk = ~clk;

  hw_sem_bank u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr_en  (bus_wr_en),
    .bus_wr_data(bus_wr_data),
    .bus_rd_en  (bus_rd_en),
    .bus_rd_data(bus_rd_data),
    .bus_master (bus_master)
  );

  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 0;
  logic [3:0]  m_own [32];
  bit          m_mode;
  logic [31:0] exp_rd;
  string       exp_tag;
  bit          exp_valid = 0;

  function automatic logic [31:0] mdl_read(input logic [7:0] a);
    if (a == 8'h00) return {31'd0, m_mode};
    if (a[1:0] == 2'b00 && a >= 8'd8 && a < 8'd136) return {28'd0, m_own[(a - 8) >> 2]};
    return 32'd0;
  endfunction

  task automatic mdl_write(input logic [7:0] a, input logic [31:0] wd, input logic [3:0] m);
    if (a == 8'h00) m_mode = wd[0];
    else if (a[1:0] == 2'b00 && a >= 8'd8 && a < 8'd136 && !m_mode) begin
      int i = (a - 8) >> 2;
      if (wd[3:0] == 4'd0) begin
        if (m_own[i] != 4'd0 && m_own[i] == m) m_own[i] = 4'd0;
      end else if (m_own[i] == 4'd0 && wd[3:0] == m) m_own[i] = wd[3:0];
    end
  endtask

  task automatic compare();
    if (exp_valid) begin
      n_checks++;
      if (bus_rd_data !== exp_rd) begin
        n_errors++;
        $display("FAIL %s: rd_data=%08h expected %08h", exp_tag, bus_rd_data, exp_rd);
      end
    end
  endtask

  task automatic step(input bit wr, input bit rd, input logic [7:0] a,
                      input logic [31:0] wd, input logic [3:0] m, input string tag);
    @(negedge clk);
    compare();
    bus_wr_en   = wr;
    bus_rd_en   = rd;
    bus_addr    = a;
    bus_wr_data = wd;
    bus_master  = m;
    exp_rd      = rd ? mdl_read(a) : 32'd0;
    exp_tag     = tag;
    exp_valid   = 1;
    if (wr) mdl_write(a, wd, m);
  endtask

  function automatic logic [7:0] sa(input int i);
    return 8'(8 + 4 * i);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) m_own[i] = 4'd0;
    m_mode = 0;
    rst_n = 0; bus_addr = 0; bus_wr_en = 0; bus_wr_data = 0; bus_rd_en = 0; bus_master = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset state
    step(0, 1, 8'h00, 0, 1, "R1");
    for (int i = 0; i < 32; i++) step(0, 1, sa(i), 0, 1, "R1");

    // R3 / R4 / R5 / R6 on semaphore 0
    step(1, 0, sa(0), 32'h1, 1, "R3");
    step(0, 1, sa(0), 0, 1, "R3");
    step(1, 0, sa(0), 32'h2, 2, "R4");
    step(0, 1, sa(0), 0, 2, "R4");
    step(1, 0, sa(0), 32'hFFFF_FFF1, 1, "R5");
    step(0, 1, sa(0), 0, 1, "R5");
    step(1, 0, sa(0), 32'h0, 2, "R6");
    step(0, 1, sa(0), 0, 2, "R6");
    step(1, 0, sa(0), 32'h0, 1, "R6");
    step(0, 1, sa(0), 0, 1, "R6");

    // R2: every slot independent
    for (int i = 0; i < 32; i++) step(1, 0, sa(i), 32'((i % 3) + 1), 4'((i % 3) + 1), "R2");
    for (int i = 0; i < 32; i++) step(0, 1, sa(i), 0, 1, "R2");
    for (int i = 0; i < 32; i++) step(1, 0, sa(i), 0, 4'((i % 3) + 1), "R2");

    // R7: claim with data not matching the master
    step(1, 0, sa(5), 32'h3, 2, "R7");
    step(0, 1, sa(5), 0, 2, "R7");

    // R8: mode register and frozen semaphores
    step(1, 0, 8'h00, 32'hFFFF_FFFF, 1, "R8");
    step(0, 1, 8'h00, 0, 1, "R8");
    step(1, 0, sa(7), 32'h1, 1, "R8");
    step(0, 1, sa(7), 0, 1, "R8");
    step(1, 0, 8'h00, 32'hFFFF_FFFE, 1, "R8");
    step(0, 1, 8'h00, 0, 1, "R8");
    step(1, 0, sa(7), 32'h1, 1, "R8");
    step(0, 1, sa(7), 0, 1, "R8");

    // R9: interrupt-clear register
    step(1, 0, 8'h90, 32'h0000_FFFF, 1, "R9");
    step(0, 1, 8'h90, 0, 1, "R9");
    step(0, 1, sa(7), 0, 1, "R9");
    step(0, 1, 8'h00, 0, 1, "R9");

    // R10: unmapped and unaligned
    step(1, 0, 8'h8A, 32'h2, 2, "R10");
    step(1, 0, 8'h0A, 32'h2, 2, "R10");
    step(1, 0, 8'h88, 32'h2, 2, "R10");
    step(1, 0, 8'h04, 32'h1, 2, "R10");
    step(0, 1, 8'h88, 0, 2, "R10");
    step(0, 1, 8'h0A, 0, 2, "R10");
    step(0, 1, 8'hFC, 0, 2, "R10");
    step(0, 1, 8'h00, 0, 2, "R10");
    step(0, 1, sa(0), 0, 2, "R10");
    step(0, 1, sa(1), 0, 2, "R10");

    // R11: read in same cycle as write sees old value, reads leave state
    step(1, 1, sa(3), 32'h1, 1, "R11");
    step(0, 1, sa(3), 0, 1, "R11");
    step(0, 1, sa(3), 0, 1, "R11");
    step(0, 0, sa(3), 0, 1, "R11");

    // Random traffic against the model
    for (int k = 0; k < 4000; k++) begin
      int r = $urandom % 12;
      logic [3:0] m = 4'(($urandom % 3) + 1);
      logic [7:0] a;
      logic [31:0] wd;
      int dsel = $urandom % 4;
      if (r < 8) a = sa((r < 5) ? ($urandom % 4) : ($urandom % 32));
      else if (r == 8) a = 8'h00;
      else if (r == 9) a = 8'h90;
      else a = 8'($urandom);
      if (a == 8'h00) wd = 32'(($urandom % 4) == 0);
      else if (dsel == 0) wd = 32'h0;
      else if (dsel == 1) wd = 32'(($urandom % 15) + 1);
      else wd = {$urandom, 4'h0} | 32'(m);
      step(($urandom % 2) == 1, ($urandom % 3) != 0, a, wd, m, "R2");
    end
    step(0, 0, 8'h00, 0, 1, "R11");
    @(negedge clk);
    compare();
    finish_run();
  end

endmodule